// File: doc/BRIEF.md
# Auxiliary-Winding Valley Qualifier

This block sits between two digitised comparators on the auxiliary-winding sense input of a quasi-resonant switching controller and the logic that decides when to turn the switch on. One comparator bit is high while the sensed voltage is above an arming level (0.5 V). The other is high while it is above a lower trigger level (0.4 V). The block turns them into a single-clock valley pulse. A falling crossing of the trigger level counts only if the signal rose past the arming level earlier in the same ringing period. The pulse is issued a fixed number of clocks after that crossing.

The controller pulses `cycle_start` on each rising edge of the gate drive. That strobe opens a mask window, and any candidate whose falling crossing lands inside the window is thrown away. The arming flag must be earned anew in each ringing period. It is cleared when a valley is issued, when a candidate is discarded, and on every strobe. Both comparator bits are asynchronous and pass through a synchroniser. The synchroniser depth, the delay and the mask are parameters counted in clock cycles.

Top module: `aux_valley_qualifier`

## Requirements
- R1: After a synchronous reset `valley` is low, the arming flag is clear and the mask window is already expired. Without any strobe, an armed falling crossing after reset yields a pulse.
- R2: A falling edge of `cmp_trig` produces no pulse unless `cmp_arm` was high earlier in the same ringing period and that arming has not since been cleared.
- R3: For an accepted crossing, `valley` is high in the clock cycle that begins SYNC_STAGES+DELAY_CYC-1 rising edges after the edge that first samples `cmp_trig` low. With the default two-stage synchroniser that is DELAY_CYC+1 edges.
- R4: `valley` is never high for two consecutive cycles.
- R5: Let P be the edge that samples `cycle_start` high and E the edge that first samples `cmp_trig` low. The candidate is discarded when (E-P)+SYNC_STAGES-1 < MASK_CYC, and accepted otherwise.
- R6: A discarded candidate clears the arming flag, so a later falling crossing in the same period with no new arming rise produces no pulse.
- R7: A `cycle_start` strobe clears the arming flag. The clear has priority over a simultaneous arming rise.
- R8: Issuing a valley clears the arming flag, so a later crossing without a new arming rise produces no pulse.
- R9: A falling crossing that is detected while a delayed pulse is pending is ignored. The pending pulse keeps its original timing and no second pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_start | input | 1 | One-clock strobe on the gate-drive rising edge; restarts the mask window |
| cmp_arm | input | 1 | Asynchronous comparator bit, high while the sense voltage is above the arming level |
| cmp_trig | input | 1 | Asynchronous comparator bit, high while the sense voltage is above the trigger level |
| valley | output | 1 | One-clock qualified valley pulse |

## Verification
The hardest situation to bring about from the ports is a second armed falling crossing that lands inside the delay of an already accepted one. Reaching it needs a rise and fall of the trigger bit squeezed between the first crossing and its pulse. The episodes place that second crossing a few clocks after the first, well before the computed pulse cycle. A design that restarts its delay, or issues two pulses, is exposed there. The mask edge also needs exact placement: directed episodes put the falling crossing one clock on each side of the window boundary, and random episodes spread offsets densely around it.

// File: rtl/avq_pkg.sv
`timescale 1ns/1ps
package avq_pkg;

  typedef enum logic [1:0] {
    FALL_NONE    = 2'd0,
    FALL_ACCEPT  = 2'd1,
    FALL_DISCARD = 2'd2,
    FALL_IGNORE  = 2'd3
  } fall_kind_t;

  // Width of a counter that must hold values 0..limit.
  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  // Decide what a detected falling crossing becomes.
  // A pending pulse wins over the mask, and the mask wins over acceptance.
  function automatic fall_kind_t classify(input logic fell, input logic armed,
                                          input logic busy, input logic masked);
    if (!fell || !armed) return FALL_NONE;
    if (busy)            return FALL_IGNORE;
    if (masked)          return FALL_DISCARD;
    return FALL_ACCEPT;
  endfunction

endpackage

// File: rtl/avq_sync.sv
`timescale 1ns/1ps
module avq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/avq_mask_timer.sv
`timescale 1ns/1ps
module avq_mask_timer
  import avq_pkg::*;
#(
  parameter int MASK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  output logic window_open
);
  localparam int W = cnt_width(MASK_CYC);
  localparam logic [W-1:0] LIMIT = W'(MASK_CYC);

  logic [W-1:0] elapsed;

  // Reset leaves the window expired; a strobe restarts the count from zero.
  always_ff @(posedge clk) begin
    if (rst)                    elapsed <= LIMIT;
    else if (cycle_start)       elapsed <= '0;
    else if (elapsed != LIMIT)  elapsed <= elapsed + 1'b1;
  end

  assign window_open = (elapsed == LIMIT);

  // Once the window has expired it stays expired until the next strobe.
  assert_window_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (window_open && !cycle_start) |=> window_open);

  // A strobe always reopens the mask on the following cycle.
  assert_strobe_masks_R5: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !window_open);
endmodule

// File: rtl/avq_arm_tracker.sv
`timescale 1ns/1ps
module avq_arm_tracker
  import avq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       arm_s,
  input  logic       trig_s,
  input  logic       cycle_start,
  input  logic       window_open,
  input  logic       busy,
  input  logic       emit,
  output logic       armed,
  output logic       trig_fell,
  output fall_kind_t kind
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= trig_s;
  end

  assign trig_fell = trig_q & ~trig_s;
  assign kind      = classify(trig_fell, armed, busy, !window_open);

  logic clear_arm;
  assign clear_arm = cycle_start | emit | (kind == FALL_DISCARD);

  always_ff @(posedge clk) begin
    if (rst)            armed <= 1'b0;
    else if (clear_arm) armed <= 1'b0;
    else if (arm_s)     armed <= 1'b1;
  end

  assert_discard_clears_arm_R6: assert property (@(posedge clk) disable iff (rst)
    (kind == FALL_DISCARD) |=> !armed);

  assert_strobe_clears_arm_R7: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !armed);

  // A crossing that is not armed never becomes anything.
  assert_unarmed_inert_R2: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (kind == FALL_NONE));
endmodule

// File: rtl/avq_delay_line.sv
`timescale 1ns/1ps
module avq_delay_line
  import avq_pkg::*;
#(
  parameter int DELAY_CYC = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int W = cnt_width(DELAY_CYC);
  localparam logic [W-1:0] RELOAD = W'(DELAY_CYC - 1);

  logic [W-1:0] remain;
  logic         pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      remain  <= '0;
    end else if (start && !pending) begin
      pending <= 1'b1;
      remain  <= RELOAD;
    end else if (pending) begin
      if (remain == '0) pending <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  assign busy = pending;
  assign fire = pending && (remain == '0);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

  // The tracker must never request a new delay while one is running.
  assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  assert_start_goes_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/aux_valley_qualifier.sv
`timescale 1ns/1ps
module aux_valley_qualifier
  import avq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DELAY_CYC   = 50,
  parameter int MASK_CYC    = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cycle_start,
  input  logic cmp_arm,
  input  logic cmp_trig,
  output logic valley
);
  logic       arm_s, trig_s;
  logic       window_open;
  logic       busy, fire;
  logic       armed, trig_fell;
  fall_kind_t kind;
  logic       accept;

  avq_sync #(.STAGES(SYNC_STAGES)) u_sync_arm (
    .clk(clk), .rst(rst), .d(cmp_arm), .q(arm_s));

  avq_sync #(.STAGES(SYNC_STAGES)) u_sync_trig (
    .clk(clk), .rst(rst), .d(cmp_trig), .q(trig_s));

  avq_mask_timer #(.MASK_CYC(MASK_CYC)) u_mask (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .window_open(window_open));

  avq_arm_tracker u_track (
    .clk(clk), .rst(rst), .arm_s(arm_s), .trig_s(trig_s),
    .cycle_start(cycle_start), .window_open(window_open), .busy(busy),
    .emit(fire), .armed(armed), .trig_fell(trig_fell), .kind(kind));

  assign accept = (kind == FALL_ACCEPT);

  avq_delay_line #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk(clk), .rst(rst), .start(accept), .busy(busy), .fire(fire));

  assign valley = fire;

  assert_emit_clears_arm_R8: assert property (@(posedge clk) disable iff (rst)
    valley |=> !armed);

  // A pulse is only issued when no falling crossing had just started a new delay.
  assert_no_accept_on_emit_R9: assert property (@(posedge clk) disable iff (rst)
    valley |-> !accept);
endmodule

// File: tb/aux_valley_qualifier_tb_top.sv
`timescale 1ns/1ps
module aux_valley_qualifier_tb_top;
  localparam int DLY  = 6;
  localparam int MSK  = 24;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst = 1'b1, cycle_start = 1'b0, cmp_arm = 1'b0, cmp_trig = 1'b0;
  logic valley;

  aux_valley_qualifier #(.SYNC_STAGES(SYNC), .DELAY_CYC(DLY), .MASK_CYC(MSK)) dut_i (
    .clk(clk), .rst(rst), .cycle_start(cycle_start),
    .cmp_arm(cmp_arm), .cmp_trig(cmp_trig), .valley(valley));

  always #10 clk = ~clk;

  int   cyc = 0, npulse = 0, last_pc = -1, wide = 0;
  logic prev_v = 1'b0;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (valley === 1'b1) begin
      npulse  = npulse + 1;
      last_pc = cyc;
      if (prev_v === 1'b1) wide = wide + 1;
    end
    prev_v = valley;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Cycle (negedge index) at which the pulse is seen for a fall driven at f.
  function automatic int pulse_at(input int f);
    return f + SYNC + DLY;
  endfunction

  // Strobe driven at s, fall driven at f: inside the mask?
  function automatic bit masked(input int s, input int f);
    return (f - s + SYNC - 1) < MSK;
  endfunction

  task automatic settle();
    tick(DLY + SYNC + 4);
  endtask

  task automatic expect_pulse(input int base, input bit want, input int at, input string tag);
    check((npulse - base) == (want ? 1 : 0), {tag, " count"}, npulse - base, want ? 1 : 0);
    if (want) check(last_pc == at, {tag, " cycle"}, last_pc, at);
  endtask

  task automatic arm_blip();
    cmp_arm = 1'b1; tick(2); cmp_arm = 1'b0; tick(1);
  endtask

  task automatic strobe();
    cycle_start = 1'b1; tick(1); cycle_start = 1'b0;
  endtask

  task automatic episode(input bit do_arm, input int d, input string tag);
    int s, f, base;
    base = npulse;
    s = cyc;
    strobe();
    cmp_trig = 1'b1; tick(1);
    cmp_arm = do_arm; tick(1);
    cmp_arm = 1'b0;
    while (cyc < s + d) tick(1);
    cmp_trig = 1'b0;
    f = cyc;
    settle();
    expect_pulse(base, do_arm && !masked(s, f), pulse_at(f), tag);
  endtask

  initial begin
    int base, f, s, f1, seed;
    seed = $urandom(32'd914);
    // R1: reset with the arming comparator held high
    cmp_arm = 1'b1;
    tick(4);
    check(valley == 1'b0, "R1 valley low during reset", valley, 0);
    cmp_arm = 1'b0; rst = 1'b0;
    tick(3);
    check(valley == 1'b0, "R1 valley low after reset", valley, 0);

    // R1: arming flag clear out of reset
    base = npulse;
    cmp_trig = 1'b1; tick(4); cmp_trig = 1'b0; settle();
    expect_pulse(base, 0, 0, "R1 arm clear after reset");

    // R1 + R3: window expired out of reset, exact latency
    base = npulse;
    cmp_trig = 1'b1; tick(1); arm_blip(); cmp_trig = 1'b0; f = cyc; settle();
    expect_pulse(base, 1, pulse_at(f), "R1 R3 window expired after reset");

    // R2: crossing with no arming rise
    episode(1'b0, MSK + 4, "R2 no arming rise");

    // R5: mask boundary and early fall
    episode(1'b1, MSK - 2, "R5 fall on last masked cycle");
    episode(1'b1, MSK - 1, "R5 fall on first open cycle");
    episode(1'b1, 4, "R5 early fall");
    episode(1'b1, MSK + 10, "R3 late fall");

    // R6: discard clears arming
    base = npulse; s = cyc;
    strobe();
    cmp_trig = 1'b1; tick(1); arm_blip(); cmp_trig = 1'b0; tick(3);
    cmp_trig = 1'b1; tick(3);
    while (cyc < s + MSK + 4) tick(1);
    cmp_trig = 1'b0; settle();
    expect_pulse(base, 0, 0, "R6 discard clears arm");

    // R7: strobe clears arming
    base = npulse;
    cmp_trig = 1'b1; tick(1); arm_blip(); tick(2);
    s = cyc; strobe();
    while (cyc < s + MSK + 4) tick(1);
    cmp_trig = 1'b0; settle();
    expect_pulse(base, 0, 0, "R7 strobe clears arm");

    // R9: second crossing while pending, then R8: emission clears arming
    s = cyc; strobe();
    while (cyc < s + MSK + 2) tick(1);
    cmp_trig = 1'b1; tick(1); arm_blip(); cmp_trig = 1'b0; f1 = cyc;
    base = npulse;
    tick(1); cmp_trig = 1'b1; cmp_arm = 1'b1; tick(1); cmp_arm = 1'b0; tick(1);
    cmp_trig = 1'b0;
    tick(8);
    cmp_trig = 1'b1; tick(3); cmp_trig = 1'b0;
    settle();
    expect_pulse(base, 1, pulse_at(f1), "R9 pending pulse kept R8 emission clears arm");

    // R8: a further unarmed crossing after the pulse
    base = npulse;
    cmp_trig = 1'b1; tick(3); cmp_trig = 1'b0; settle();
    expect_pulse(base, 0, 0, "R8 no pulse after emission");

    // Random episodes around the mask boundary
    for (int i = 0; i < 40; i++) begin
      bit a;
      int d;
      a = ($urandom_range(0, 3) != 0);
      d = $urandom_range(4, MSK + 12);
      episode(a, d, "R3 R5 random episode");
    end

    check(wide == 0, "R4 pulse width", wide, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule